// File: doc/BRIEF.md
# 100BASE-X Receive Carrier Sense Detector

This block watches the stream of code bits arriving from a 100 Mb/s twisted-pair receiver. The bits are taken after line decoding and descrambling, but before 5B/4B data decoding. The block drives a carrier-sense output for the MAC side.

Carrier starts early, on a sparse pattern of zeros, before any symbol alignment is known. The block then hunts for the start-of-stream pair J/K. Once it finds the pair, it locks 5-bit symbol boundaries to it. From then on it looks at whole symbols:

- a T/R pair or an IDLE/IDLE pair ends the frame;
- a lone T or a lone IDLE only drops carrier until the next symbol shows whether the frame really ended.

A burst of zeros that never grows into a J/K pair is rejected once ten ones in a row arrive.

The outgoing carrier sense also includes local transmit activity. This holds only in half-duplex, non-repeater operation.

Top module: `carrier_sense_det`

## Requirements
- R1: With no carrier active, a strobed `0` bit starts carrier when at least one other `0` lies 2 to 9 bit positions earlier in the strobed stream. Two adjacent zeros, or two zeros 10 positions apart, start nothing. `rx_active` and the receive part of `crs` go high after the edge that takes in the starting bit.
- R2: While carrier is up and no J/K pair has been found, ten consecutive `1` bits drop carrier (false carrier). `rx_active` is low after the edge that takes in the tenth one.
- R3: The bit pattern `1100010001` (J=`11000` then K=`10001`, first-received bit leftmost) locks symbol alignment. The next five bits form the first symbol. Alignment then stays fixed until carrier ends, so code patterns straddling symbol boundaries are not recognised.
- R4: With alignment locked, the receive part of `crs` falls after the last bit of a T symbol (`01101`) or an IDLE symbol (`11111`), while `rx_active` stays high.
- R5: A T followed by R (`00111`), or an IDLE followed by IDLE, ends the frame: `rx_active` goes low after the last bit of the second symbol.
- R6: If the symbol after a T is not R, or the symbol after an IDLE is not IDLE, the receive part of `crs` rises again after that symbol's last bit. The exception is when that symbol is itself T or IDLE, which is handled as in R4.
- R7: When `full_duplex` or `repeater` is high, `crs` reflects receive carrier only. Otherwise `crs` is high whenever `tx_en` is high or receive carrier is up.
- R8: A high `rst`, sampled on a clock edge, clears all state; `crs` (absent transmit) and `rx_active` are low afterwards.
- R9: When carrier ends, the bit history is emptied. Zeros received before the end therefore cannot pair with a later single zero to restart carrier.
- R10: Clock edges with `bit_vld` low leave all receive state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new code bit this cycle |
| bit_in | input | 1 | Received code bit, in arrival order |
| tx_en | input | 1 | Local transmitter is sending |
| full_duplex | input | 1 | Full-duplex operation |
| repeater | input | 1 | Repeater operation |
| crs | output | 1 | Carrier sense (receive, optionally merged with transmit) |
| rx_active | output | 1 | A receive event is in progress, including a pending end |

## Verification
The properties assume that `bit_in` matters only on strobed cycles and that the mode pins change only between scenarios. The bench obeys both: it changes `bit_in` only together with `bit_vld`, and sets the mode pins while the receive path is idle.

Each frame starts after at least a dozen ones. This keeps the history free of leftover zeros, so the exact bit on which carrier rises is known in advance. Symbols after J/K are chosen so that only the intended delimiters appear at aligned positions. One frame deliberately hides a T across a symbol boundary.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_HUNT,
    ST_LOCK,
    ST_AFT_T,
    ST_AFT_I
  } cs_state_t;

  typedef enum logic [2:0] {
    SC_DATA,
    SC_J,
    SC_K,
    SC_T,
    SC_R,
    SC_IDLE
  } sym_cls_t;

  function automatic sym_cls_t classify(input logic [SYM_W-1:0] s);
    case (s)
      SYM_J:    return SC_J;
      SYM_K:    return SC_K;
      SYM_T:    return SC_T;
      SYM_R:    return SC_R;
      SYM_IDLE: return SC_IDLE;
      default:  return SC_DATA;
    endcase
  endfunction

  function automatic logic crs_merge(input logic rx, input logic tx,
                                     input logic fd, input logic rep);
    return rx | (tx & ~(fd | rep));
  endfunction

endpackage

// File: rtl/cs_bit_window.sv
module cs_bit_window #(
  parameter int SYM_W = cs_pkg::SYM_W,
  parameter int WIN_W = 2 * SYM_W
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic clear,
  output logic start_hit,
  output logic jk_hit
);
  localparam int HIST_W = WIN_W - 1;
  localparam int JK_W   = 2 * SYM_W;

  logic [HIST_W-1:0] hist;
  logic [WIN_W-1:0]  window;
  logic              far_zero;

  always_ff @(posedge clk) begin
    if (rst || clear)
      hist <= '1;
    else if (bit_vld)
      hist <= {hist[HIST_W-2:0], bit_in};
  end

  assign window = {hist, bit_in};

  // zero at lag 2..WIN_W-1 (lag 1 is adjacent and excluded)
  always_comb begin
    far_zero = 1'b0;
    for (int i = 1; i < HIST_W; i++)
      if (!hist[i]) far_zero = 1'b1;
  end

  assign start_hit = bit_vld & ~bit_in & far_zero;
  assign jk_hit    = bit_vld &
                     (window[JK_W-1:0] == {cs_pkg::SYM_J, cs_pkg::SYM_K});

endmodule

// File: rtl/cs_symbol_framer.sv
module cs_symbol_framer #(
  parameter int SYM_W = cs_pkg::SYM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             align,
  input  logic             lock,
  output logic             sym_done,
  output logic [SYM_W-1:0] sym_val
);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

  logic [PH_W-1:0]  phase;
  logic [SYM_W-2:0] sr;

  always_ff @(posedge clk) begin
    if (rst || align) begin
      phase <= '0;
      sr    <= '0;
    end else if (bit_vld && lock) begin
      sr    <= {sr[SYM_W-3:0], bit_in};
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign sym_done = bit_vld & lock & ~align & (phase == PH_LAST);
  assign sym_val  = {sr, bit_in};

endmodule

// File: rtl/cs_carrier_fsm.sv
module cs_carrier_fsm #(
  parameter int FALSE_ONES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              start_hit,
  input  logic              jk_hit,
  input  logic              sym_done,
  input  cs_pkg::sym_cls_t  sym_cls,
  output logic              align,
  output logic              lock,
  output logic              hist_clear,
  output logic              false_end,
  output logic              rx_crs,
  output logic              rx_active
);
  import cs_pkg::*;

  localparam int CNT_W = $clog2(FALSE_ONES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FALSE_ONES - 1);

  cs_state_t       st, st_n;
  logic [CNT_W-1:0] ones, ones_n;

  always_comb begin
    st_n       = st;
    ones_n     = ones;
    align      = 1'b0;
    hist_clear = 1'b0;
    false_end  = 1'b0;
    case (st)
      ST_SEARCH: begin
        if (start_hit) begin
          st_n   = ST_HUNT;
          ones_n = '0;
        end
      end
      ST_HUNT: begin
        if (bit_vld) begin
          if (jk_hit) begin
            st_n  = ST_LOCK;
            align = 1'b1;
          end else if (bit_in) begin
            if (ones == CNT_LAST) begin
              st_n       = ST_SEARCH;
              hist_clear = 1'b1;
              false_end  = 1'b1;
            end else begin
              ones_n = ones + 1'b1;
            end
          end else begin
            ones_n = '0;
          end
        end
      end
      ST_LOCK: begin
        if (sym_done) begin
          if (sym_cls == SC_T)         st_n = ST_AFT_T;
          else if (sym_cls == SC_IDLE) st_n = ST_AFT_I;
        end
      end
      ST_AFT_T: begin
        if (sym_done) begin
          case (sym_cls)
            SC_R:    begin st_n = ST_SEARCH; hist_clear = 1'b1; end
            SC_T:    st_n = ST_AFT_T;
            SC_IDLE: st_n = ST_AFT_I;
            default: st_n = ST_LOCK;
          endcase
        end
      end
      ST_AFT_I: begin
        if (sym_done) begin
          case (sym_cls)
            SC_IDLE: begin st_n = ST_SEARCH; hist_clear = 1'b1; end
            SC_T:    st_n = ST_AFT_T;
            default: st_n = ST_LOCK;
          endcase
        end
      end
      default: st_n = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_SEARCH;
      ones <= '0;
    end else begin
      st   <= st_n;
      ones <= ones_n;
    end
  end

  assign lock      = (st == ST_LOCK) || (st == ST_AFT_T) || (st == ST_AFT_I);
  assign rx_crs    = (st == ST_HUNT) || (st == ST_LOCK);
  assign rx_active = (st != ST_SEARCH);

endmodule

// File: rtl/carrier_sense_det.sv
module carrier_sense_det #(
  parameter int SYM_W      = cs_pkg::SYM_W,
  parameter int WIN_W      = 2 * SYM_W,
  parameter int FALSE_ONES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic tx_en,
  input  logic full_duplex,
  input  logic repeater,
  output logic crs,
  output logic rx_active
);
  import cs_pkg::*;

  logic             start_hit_w;
  logic             jk_hit_w;
  logic             align_w;
  logic             lock_w;
  logic             hist_clear_w;
  logic             false_end_w;
  logic             rx_crs_w;
  logic             sym_done_w;
  logic [SYM_W-1:0] sym_val_w;
  sym_cls_t         sym_cls_w;

  cs_bit_window #(.SYM_W(SYM_W), .WIN_W(WIN_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .clear     (hist_clear_w),
    .start_hit (start_hit_w),
    .jk_hit    (jk_hit_w)
  );

  cs_symbol_framer #(.SYM_W(SYM_W)) u_frm (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .align    (align_w),
    .lock     (lock_w),
    .sym_done (sym_done_w),
    .sym_val  (sym_val_w)
  );

  assign sym_cls_w = classify(sym_val_w);

  cs_carrier_fsm #(.FALSE_ONES(FALSE_ONES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .start_hit  (start_hit_w),
    .jk_hit     (jk_hit_w),
    .sym_done   (sym_done_w),
    .sym_cls    (sym_cls_w),
    .align      (align_w),
    .lock       (lock_w),
    .hist_clear (hist_clear_w),
    .false_end  (false_end_w),
    .rx_crs     (rx_crs_w),
    .rx_active  (rx_active)
  );

  assign crs = crs_merge(rx_crs_w, tx_en, full_duplex, repeater);

endmodule

// File: rtl/cs_checker.sv
module cs_checker (
  input logic       clk,
  input logic       rst,
  input logic       bit_vld,
  input logic       tx_en,
  input logic       full_duplex,
  input logic       repeater,
  input logic       crs,
  input logic       rx_active,
  input logic       rx_crs,
  input logic       start_hit,
  input logic       false_end,
  input logic       align,
  input logic       lock,
  input logic       sym_done,
  input logic [4:0] sym_val
);
  logic ends_sym;
  assign ends_sym = (sym_val == 5'b01101) || (sym_val == 5'b11111);

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (!rx_active && start_hit) |=> rx_active);

  p_false_end_r2: assert property (@(posedge clk) disable iff (rst)
    false_end |=> !rx_active);

  p_lock_after_align_r3: assert property (@(posedge clk) disable iff (rst)
    align |=> (lock && rx_crs));

  p_term_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (sym_done && rx_crs && lock && ends_sym) |=> (!rx_crs && rx_active));

  p_crs_within_active_r5: assert property (@(posedge clk) disable iff (rst)
    rx_crs |-> rx_active);

  p_rx_only_r7: assert property (@(posedge clk) disable iff (rst)
    ((full_duplex || repeater) && !rx_crs) |-> !crs);

  p_tx_merge_r7: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && !repeater && tx_en) |-> crs);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!rx_active && !lock));

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(rx_active) && $stable(rx_crs)));

endmodule

bind carrier_sense_det cs_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_vld     (bit_vld),
  .tx_en       (tx_en),
  .full_duplex (full_duplex),
  .repeater    (repeater),
  .crs         (crs),
  .rx_active   (rx_active),
  .rx_crs      (rx_crs_w),
  .start_hit   (start_hit_w),
  .false_end   (false_end_w),
  .align       (align_w),
  .lock        (lock_w),
  .sym_done    (sym_done_w),
  .sym_val     (sym_val_w)
);

// File: tb/carrier_sense_det_bench.sv
module carrier_sense_det_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b1;
  logic tx_en = 1'b0;
  logic full_duplex = 1'b1;
  logic repeater = 1'b0;
  logic crs;
  logic rx_active;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] C_J = 5'b11000, C_K = 5'b10001, C_T = 5'b01101,
                         C_R = 5'b00111, C_I = 5'b11111;
  localparam logic [4:0] D0 = 5'b11110, D1 = 5'b01001, D2 = 5'b10100;

  carrier_sense_det u_carrier_sense_det (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .tx_en(tx_en), .full_duplex(full_duplex), .repeater(repeater),
    .crs(crs), .rx_active(rx_active)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive one bit away from the edge; return just after the edge that takes it
  task automatic send_bit(input logic b);
    bit_vld = 1'b1;
    bit_in  = b;
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) send_bit(s[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic open_frame;
    send_ones(12);
    send_sym(C_J);
    send_sym(C_K);
  endtask

  task automatic t_reset;
    check("R8", "crs in reset", crs, 1'b0);
    check("R8", "rx_active in reset", rx_active, 1'b0);
  endtask

  task automatic t_valid_frame;
    send_ones(12);
    send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    check("R1", "crs after adjacent zeros", crs, 1'b0);
    send_bit(0);
    check("R1", "crs after lag-2 zero", crs, 1'b1);
    send_sym(C_K);
    check("R3", "crs after J/K", crs, 1'b1);
    send_sym(D0); send_sym(D1);
    // 10110 11010 holds a T shifted by one bit: must not be recognised
    send_sym(5'b10110); send_sym(5'b11010);
    check("R3", "crs after misaligned T pattern", crs, 1'b1);
    send_sym(D2);
    send_sym(C_T);
    check("R4", "crs after T", crs, 1'b0);
    check("R4", "rx_active after T", rx_active, 1'b1);
    send_sym(C_R);
    check("R5", "rx_active after T/R", rx_active, 1'b0);
    send_bit(0);
    check("R9", "crs after lone zero past frame end", crs, 1'b0);
    send_ones(10);
    check("R9", "rx_active stays low", rx_active, 1'b0);
  endtask

  task automatic t_false_carrier;
    send_ones(12);
    send_bit(0); idle_gap(3); send_bit(1); idle_gap(2); send_bit(0);
    check("R1", "crs after 0,1,0 with gaps", crs, 1'b1);
    idle_gap(4);
    check("R10", "rx_active held over unstrobed cycles", rx_active, 1'b1);
    send_ones(9);
    check("R2", "crs after nine ones", crs, 1'b1);
    send_bit(1);
    check("R2", "crs after tenth one", crs, 1'b0);
    check("R2", "rx_active after tenth one", rx_active, 1'b0);
  endtask

  task automatic t_window_edges;
    send_ones(12);
    send_bit(0); send_ones(8); send_bit(0);
    check("R1", "zeros 9 apart start carrier", crs, 1'b1);
    send_ones(10);
    check("R2", "false carrier clears", rx_active, 1'b0);
    send_bit(0); send_ones(9); send_bit(0);
    check("R1", "zeros 10 apart no carrier", crs, 1'b0);
    send_ones(12);
  endtask

  task automatic t_t_not_r;
    open_frame();
    send_sym(D1);
    send_sym(C_T);
    check("R4", "crs low after T", crs, 1'b0);
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    check("R6", "crs low mid symbol after T", crs, 1'b0);
    send_bit(0);
    check("R6", "crs back after T + data", crs, 1'b1);
    send_sym(C_T); send_sym(C_R);
    check("R5", "frame ends on T/R", rx_active, 1'b0);
  endtask

  task automatic t_idle_pair;
    open_frame();
    send_sym(D2);
    send_sym(C_I);
    check("R4", "crs low after first IDLE", crs, 1'b0);
    check("R4", "rx_active held after first IDLE", rx_active, 1'b1);
    send_sym(C_I);
    check("R5", "rx_active after IDLE pair", rx_active, 1'b0);
    open_frame();
    send_sym(C_I);
    send_sym(D0);
    check("R6", "crs back after IDLE + data", crs, 1'b1);
    send_sym(C_T); send_sym(C_R);
    check("R5", "rx_active after closing T/R", rx_active, 1'b0);
  endtask

  task automatic t_tx_merge;
    full_duplex = 1'b0; repeater = 1'b0; tx_en = 1'b1;
    #1 check("R7", "half duplex tx drives crs", crs, 1'b1);
    full_duplex = 1'b1;
    #1 check("R7", "full duplex ignores tx", crs, 1'b0);
    full_duplex = 1'b0; repeater = 1'b1;
    #1 check("R7", "repeater ignores tx", crs, 1'b0);
    open_frame();
    send_sym(C_T);
    check("R7", "repeater: crs follows rx only", crs, 1'b0);
    send_sym(C_R);
    repeater = 1'b0; tx_en = 1'b0; full_duplex = 1'b1;
    #1 check("R7", "no tx no rx", crs, 1'b0);
  endtask

  task automatic t_reset_mid;
    open_frame();
    check("R3", "carrier up before reset", crs, 1'b1);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check("R8", "crs after mid-frame reset", crs, 1'b0);
    check("R8", "rx_active after mid-frame reset", rx_active, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    t_valid_frame();
    t_false_carrier();
    t_window_edges();
    t_t_not_r();
    t_idle_pair();
    t_tx_merge();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule